// File: doc/BRIEF.md
# Per-Port Token Rate Limiter

This block paces the transmit side of a single output port. It keeps a debt counter. Each packet that is allowed to start adds a fixed overhead charge to the counter, plus a charge for each 64-bit (8-byte) data word in the packet. The counter drains by a constant amount on every clock and never goes below zero. The port is told it may start a new packet only while the debt stays at or below a programmed ceiling. A packet that has already started is never interrupted, because permission is looked at only when a packet starts.

Three write ports load the configuration:
- the per-packet charge,
- the per-word charge,
- the ceiling.

The per-packet charge and the ceiling are stored in units 256 times coarser than the per-word charge.

For limiting by bit rate, software folds the fixed framing overhead of each packet into the per-packet charge. That overhead is 24 bytes: 12 of gap, 8 of preamble and 4 of CRC. For limiting by packet rate, software sets the per-word charge to zero, so packet length no longer matters. The ceiling sets how much traffic can pass back-to-back before pacing begins.

Top module: `port_token_limiter`

## Requirements
- R1: A synchronous active-high reset clears the debt and all three configuration values to zero. With the debt at zero, `send_ok` is high in the first cycle after reset.
- R2: `send_ok` is high exactly when the debt is less than or equal to the ceiling multiplied by 256. Equality still permits a send.
- R3: When `pkt_start` is high and `send_ok` is high at a clock edge, the packet is accepted. After that edge the debt equals the drained old debt plus (packet charge × 256) plus (`pkt_words` × word charge).
- R4: On every clock edge the debt first drops by 16, or to zero if it was below 16. This holds whether or not a packet is accepted.
- R5: The addition on acceptance saturates at 2^DEBT_W − 1 instead of wrapping.
- R6: A `pkt_start` that arrives while `send_ok` is low is ignored. It adds no charge, and the debt only drains.
- R7: A configuration write updates its register at the clock edge where its write strobe is high. A packet accepted at that same edge is charged with the old values. Later packets and the `send_ok` compare use the new values.
- R8: With the word charge at zero, the debt added per accepted packet does not depend on `pkt_words`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pkt_we | input | 1 | Write strobe for the per-packet charge |
| cfg_pkt_cost | input | PKT_COST_W | Per-packet charge, in units of 256 |
| cfg_word_we | input | 1 | Write strobe for the per-word charge |
| cfg_word_cost | input | WORD_COST_W | Per-word charge, in units of 1 |
| cfg_lim_we | input | 1 | Write strobe for the ceiling |
| cfg_limit | input | LIMIT_W | Debt ceiling, in units of 256 |
| pkt_start | input | 1 | Request to start a packet in this cycle |
| pkt_words | input | WCNT_W | Number of 64-bit words in the starting packet |
| send_ok | output | 1 | High while a new packet may start |

## Verification
The bench runs a cycle-accurate reference of the debt and compares `send_ok` on every cycle. The corner cases it targets are listed below, each with the failure it would expose.

- **Debt exactly equal to the scaled ceiling.** A strict compare would block one packet too early here.
- **Drain near zero.** A drain without a floor would wrap and hold the port off for a very long time.
- **Oversized packet.** A charge that wraps instead of saturating would leave only a small debt and let the next packet through at once.
- **Repeated starts while blocked.** A design that charges ignored starts would stretch the hold-off.
- **Configuration write at the same edge as a packet.** Using the new charge early would shift when `send_ok` rises.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    localparam int GRAN_SHIFT_DEF = 8;
    localparam int DRAIN_DEF      = 16;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int charge_width(input int pkt_w, input int gran,
                                        input int wcnt_w, input int word_w);
        return max_int(pkt_w + gran, wcnt_w + word_w) + 1;
    endfunction

endpackage

// File: rtl/ptl_cfg_reg.sv
module ptl_cfg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/ptl_charge.sv
module ptl_charge #(
    parameter int PKT_COST_W  = 16,
    parameter int WORD_COST_W = 12,
    parameter int WCNT_W      = 11,
    parameter int GRAN        = 8,
    parameter int CHG_W       = 25
) (
    input  logic [PKT_COST_W-1:0]  pkt_cost,
    input  logic [WORD_COST_W-1:0] word_cost,
    input  logic [WCNT_W-1:0]      words,
    output logic [CHG_W-1:0]       charge
);
    localparam int PP_W = PKT_COST_W + GRAN;
    localparam int WP_W = WCNT_W + WORD_COST_W;

    logic [PP_W-1:0] pkt_part;
    logic [WP_W-1:0] word_part;

    always_comb begin
        pkt_part  = {pkt_cost, {GRAN{1'b0}}};
        word_part = WP_W'(words) * WP_W'(word_cost);
        charge    = CHG_W'(pkt_part) + CHG_W'(word_part);
    end
endmodule

// File: rtl/ptl_debt.sv
module ptl_debt #(
    parameter int DEBT_W  = 24,
    parameter int CHG_W   = 25,
    parameter int LIMIT_W = 16,
    parameter int GRAN    = 8,
    parameter int DRAIN   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [CHG_W-1:0]   charge,
    input  logic [LIMIT_W-1:0] limit,
    output logic [DEBT_W-1:0]  debt_q,
    output logic               send_ok
);
    localparam int SUM_W = ptl_pkg::max_int(DEBT_W, CHG_W) + 1;
    localparam int LS_W  = LIMIT_W + GRAN;
    localparam int CMP_W = ptl_pkg::max_int(DEBT_W, LS_W);
    localparam logic [DEBT_W-1:0] DRAIN_V = DEBT_W'(DRAIN);
    localparam logic [SUM_W-1:0]  CEIL    = SUM_W'({DEBT_W{1'b1}});

    logic [DEBT_W-1:0] drained;
    logic [SUM_W-1:0]  sum;
    logic [DEBT_W-1:0] debt_d;
    logic [LS_W-1:0]   lim_scaled;

    always_comb begin
        drained = (debt_q >= DRAIN_V) ? (debt_q - DRAIN_V) : '0;
        sum     = SUM_W'(drained) + SUM_W'(charge);
        if (!accept)
            debt_d = drained;
        else if (sum > CEIL)
            debt_d = {DEBT_W{1'b1}};
        else
            debt_d = sum[DEBT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            debt_q <= '0;
        else
            debt_q <= debt_d;
    end

    always_comb begin
        lim_scaled = {limit, {GRAN{1'b0}}};
        send_ok    = CMP_W'(debt_q) <= CMP_W'(lim_scaled);
    end
endmodule

// File: rtl/port_token_limiter.sv
module port_token_limiter #(
    parameter int PKT_COST_W  = 16,
    parameter int WORD_COST_W = 12,
    parameter int LIMIT_W     = 16,
    parameter int WCNT_W      = 11,
    parameter int DEBT_W      = 24,
    parameter int GRAN        = ptl_pkg::GRAN_SHIFT_DEF,
    parameter int DRAIN       = ptl_pkg::DRAIN_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_pkt_we,
    input  logic [PKT_COST_W-1:0]  cfg_pkt_cost,
    input  logic                   cfg_word_we,
    input  logic [WORD_COST_W-1:0] cfg_word_cost,
    input  logic                   cfg_lim_we,
    input  logic [LIMIT_W-1:0]     cfg_limit,
    input  logic                   pkt_start,
    input  logic [WCNT_W-1:0]      pkt_words,
    output logic                   send_ok
);
    localparam int CHG_W = ptl_pkg::charge_width(PKT_COST_W, GRAN, WCNT_W, WORD_COST_W);

    logic [PKT_COST_W-1:0]  pkt_cost_q;
    logic [WORD_COST_W-1:0] word_cost_q;
    logic [LIMIT_W-1:0]     limit_q;
    logic [CHG_W-1:0]       charge;
    logic [DEBT_W-1:0]      debt_q;
    logic                   accept;

    ptl_cfg_reg #(.W(PKT_COST_W)) u_pkt_reg (
        .clk(clk), .rst(rst), .we(cfg_pkt_we), .d(cfg_pkt_cost), .q(pkt_cost_q));

    ptl_cfg_reg #(.W(WORD_COST_W)) u_word_reg (
        .clk(clk), .rst(rst), .we(cfg_word_we), .d(cfg_word_cost), .q(word_cost_q));

    ptl_cfg_reg #(.W(LIMIT_W)) u_lim_reg (
        .clk(clk), .rst(rst), .we(cfg_lim_we), .d(cfg_limit), .q(limit_q));

    ptl_charge #(
        .PKT_COST_W(PKT_COST_W), .WORD_COST_W(WORD_COST_W),
        .WCNT_W(WCNT_W), .GRAN(GRAN), .CHG_W(CHG_W)
    ) u_charge (
        .pkt_cost(pkt_cost_q), .word_cost(word_cost_q),
        .words(pkt_words), .charge(charge));

    assign accept = pkt_start & send_ok;

    ptl_debt #(
        .DEBT_W(DEBT_W), .CHG_W(CHG_W), .LIMIT_W(LIMIT_W),
        .GRAN(GRAN), .DRAIN(DRAIN)
    ) u_debt (
        .clk(clk), .rst(rst), .accept(accept), .charge(charge),
        .limit(limit_q), .debt_q(debt_q), .send_ok(send_ok));
endmodule

// File: rtl/port_token_limiter_chk.sv
module port_token_limiter_chk #(
    parameter int DEBT_W = 24,
    parameter int DRAIN  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pkt_start,
    input logic              send_ok,
    input logic              cfg_lim_we,
    input logic              accept,
    input logic [DEBT_W-1:0] debt
);
    localparam logic [DEBT_W-1:0] DV = DEBT_W'(DRAIN);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (debt == '0 && send_ok)); // R1

    AST_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (send_ok && !pkt_start && !cfg_lim_we) |=> send_ok); // R2

    AST_DRAIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        !accept |=> debt == (($past(debt) >= DV) ? ($past(debt) - DV) : '0)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        accept |=> debt >= (($past(debt) >= DV) ? ($past(debt) - DV) : '0)); // R5

    AST_BLOCKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && !send_ok) |=> debt < $past(debt)); // R6
endmodule

bind port_token_limiter port_token_limiter_chk #(.DEBT_W(DEBT_W), .DRAIN(DRAIN)) u_chk (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .send_ok(send_ok),
    .cfg_lim_we(cfg_lim_we), .accept(accept), .debt(debt_q));

// File: tb/sim_port_token_limiter.sv
module sim_port_token_limiter;
    localparam int CLK_PERIOD = 10;
    localparam longint DMAX   = (64'd1 << 24) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_pkt_we = 1'b0, cfg_word_we = 1'b0, cfg_lim_we = 1'b0;
    logic [15:0] cfg_pkt_cost = '0;
    logic [11:0] cfg_word_cost = '0;
    logic [15:0] cfg_limit = '0;
    logic        pkt_start = 1'b0;
    logic [10:0] pkt_words = '0;
    logic        send_ok;

    typedef struct { bit exp; string tag; } item_t;
    item_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    longint m_debt = 0, m_pc = 0, m_wc = 0, m_lim = 0;

    port_token_limiter u0 (
        .clk(clk), .rst(rst),
        .cfg_pkt_we(cfg_pkt_we), .cfg_pkt_cost(cfg_pkt_cost),
        .cfg_word_we(cfg_word_we), .cfg_word_cost(cfg_word_cost),
        .cfg_lim_we(cfg_lim_we), .cfg_limit(cfg_limit),
        .pkt_start(pkt_start), .pkt_words(pkt_words), .send_ok(send_ok));

    always #(CLK_PERIOD/2) clk = ~clk;

    // driver: one clock edge, reference update, expected value queued
    task automatic tick(input string tag);
        longint dr, nx;
        bit ok;
        @(posedge clk);
        if (rst) begin
            m_debt = 0; m_pc = 0; m_wc = 0; m_lim = 0;
        end else begin
            ok = (m_debt <= m_lim * 256);
            dr = (m_debt >= 16) ? m_debt - 16 : 0;
            nx = dr;
            if (pkt_start && ok) begin
                nx = dr + m_pc * 256 + longint'(pkt_words) * m_wc;
                if (nx > DMAX) nx = DMAX;
            end
            m_debt = nx;
            if (cfg_pkt_we)  m_pc  = cfg_pkt_cost;
            if (cfg_word_we) m_wc  = cfg_word_cost;
            if (cfg_lim_we)  m_lim = cfg_limit;
        end
        q.push_back('{exp: (m_debt <= m_lim * 256), tag: tag});
        #1;
        pkt_start = 0; cfg_pkt_we = 0; cfg_word_we = 0; cfg_lim_we = 0;
    endtask

    task automatic write_cfg(input int pc, input int wc, input int lim, input string tag);
        cfg_pkt_we = 1; cfg_pkt_cost = 16'(pc);
        cfg_word_we = 1; cfg_word_cost = 12'(wc);
        cfg_lim_we = 1; cfg_limit = 16'(lim);
        tick(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (send_ok !== it.exp) begin
                errors++;
                $display("FAIL %s: send_ok actual=%b expected=%b at %0t", it.tag, send_ok, it.exp, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(3, "R1");
        rst = 0;
        idle(2, "R1");

        // R8 packet-rate mode: word cost zero, lengths vary; R6 blocked starts ignored
        write_cfg(2, 0, 3, "R8");
        for (int i = 0; i < 120; i++) begin
            pkt_start = 1;
            pkt_words = 11'((i % 3 == 0) ? 5 : 1500);
            tick((i % 2 == 0) ? "R8" : "R6");
        end
        idle(80, "R4");

        // R3 bit-rate mode: overhead plus per-word charge
        write_cfg(3, 64, 1, "R3");
        for (int i = 0; i < 60; i++) begin
            pkt_start = 1;
            pkt_words = 11'(10 + i);
            tick("R3");
        end
        // R4 drain floors at zero
        idle(200, "R4");

        // R2 boundary: debt equal to ceiling*256 still permits
        write_cfg(2, 0, 2, "R2");
        pkt_start = 1; pkt_words = 11'd7; tick("R2");
        pkt_start = 1; pkt_words = 11'd7; tick("R2");
        idle(40, "R2");

        // R7 write at same edge as accepted packet: old charge used
        cfg_pkt_we = 1; cfg_pkt_cost = 16'd100;
        pkt_start = 1; pkt_words = 11'd3;
        tick("R7");
        idle(10, "R7");
        pkt_start = 1; pkt_words = 11'd3; tick("R7");
        idle(1700, "R7");
        cfg_lim_we = 1; cfg_limit = 16'd0; tick("R7");
        idle(5, "R7");

        // R5 saturation on oversized packet
        write_cfg(16'hFFFF, 12'hFFF, 16'hFFFF, "R5");
        idle(2, "R5");
        pkt_start = 1; pkt_words = 11'h7FF; tick("R5");
        idle(24, "R5");

        idle(2, "R1");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule